// File: doc/BRIEF.md
# Channel-Blocked Matrix MAC Tile

This block is the arithmetic core of a multi-channel 3x3 convolution, recast as a small matrix product. Each issue carries two operands. The first holds four output-row pixels taken from each of eight input channels. The second holds the weights that map those eight input channels onto four output channels. The block forms the 4x4 product, which covers four pixels by four output channels, in a single issue. It turns 32 input samples into 16 results.

The products can either replace the contents of a 16-lane accumulator or be added to it. Partial sums can then build up across the nine kernel taps and across successive groups of eight input channels. The weight operand does not depend on pixel position, so the caller can hold it steady while pixel groups from the same image stream through, one issue per cycle. A synchronous clear empties the accumulator. Results leave through a two-stage pipeline with a matching valid strobe.

Top module: `chblk_mac_tile`

## Requirements
- R1: With in_valid_i high and acc_i and clr_i low, the result lane for pixel p and output channel co equals the sum over ci of X(p,ci)*W(ci,co). X(p,ci) is the signed 8-bit value in x_i bits [(p*8+ci)*8 +: 8].
- R2: W(ci,co) is the signed 8-bit value in y_i bits [(ci*4+co)*8 +: 8]. Rows of the weight operand are input channels and columns are output channels.
- R3: Result lane p*4+co sits in m_o bits [(p*4+co)*24 +: 24] as a signed 24-bit value. The extreme case, -128 times -128 summed over 8 channels, reads 131072.
- R4: An issue with acc_i low overwrites all 16 accumulator lanes with the new products.
- R5: An issue with acc_i high adds the products to the accumulator lane by lane, wrapping modulo 2^24.
- R6: out_valid_o goes high exactly two clock edges after each edge that samples in_valid_i high, and at no other time. The result for that issue appears on m_o in the same cycle. A new issue is accepted every cycle.
- R7: clr_i high with in_valid_i low sets all 16 lanes of m_o to zero two edges later.
- R8: clr_i high with in_valid_i high overwrites the accumulator with the new products, whatever acc_i is. Clear takes priority over accumulate.
- R9: A cycle with in_valid_i and clr_i both low leaves m_o unchanged.
- R10: While rst_ni is low, out_valid_o is low and m_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Issue strobe for one operand pair |
| acc_i | input | 1 | Add products to accumulator instead of overwriting |
| clr_i | input | 1 | Synchronous accumulator clear, priority over acc_i |
| x_i | input | 256 | Pixel operand, 32 signed 8-bit lanes, pixel-major |
| y_i | input | 256 | Weight operand, 32 signed 8-bit lanes, input-channel-major |
| out_valid_o | output | 1 | Result strobe |
| m_o | output | 384 | Accumulator, 16 signed 24-bit lanes, pixel-major |

## Verification
The bound checker tests the following on every cycle: the two-cycle valid alignment, a standalone clear zeroing the accumulator, the accumulator holding still on idle cycles, and an all-zero pixel operand producing zero when the issue overwrites. It cannot confirm lane packing, arithmetic values, wraparound or the clear-over-accumulate priority. The bench's scenarios establish those: one-hot lanes, extreme signed operands, long accumulate runs, and a random mix of issues, clears and gaps, all compared against a reference accumulator computed in the bench.

// File: rtl/chblk_mac_pkg.sv
package chblk_mac_pkg;
  localparam int unsigned NPIX = 4;
  localparam int unsigned NCI  = 8;
  localparam int unsigned NCO  = 4;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 24;
  localparam int unsigned SW   = 2 * DW + $clog2(NCI);
endpackage

// File: rtl/chblk_dot.sv
module chblk_dot #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 2 * DW + $clog2(N)
) (
  input  logic [N*DW-1:0]     a_i,
  input  logic [N*DW-1:0]     b_i,
  output logic signed [SW-1:0] sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N; k++) begin
      sum_o = sum_o + SW'($signed(a_i[k*DW +: DW]) * $signed(b_i[k*DW +: DW]));
    end
  end
endmodule

// File: rtl/chblk_prod_stage.sv
module chblk_prod_stage #(
  parameter int unsigned NPIX = 4,
  parameter int unsigned NCI  = 8,
  parameter int unsigned NCO  = 4,
  parameter int unsigned DW   = 8,
  parameter int unsigned SW   = 2 * DW + $clog2(NCI),
  localparam int unsigned NOUT = NPIX * NCO
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NPIX*NCI*DW-1:0] x_i,
  input  logic [NCI*NCO*DW-1:0]  y_i,
  output logic [NOUT*SW-1:0]     sum_q_o
);
  logic [NOUT*SW-1:0] sum_d;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    for (genvar co = 0; co < NCO; co++) begin : g_och
      logic [NCI*DW-1:0] wcol;
      // gather column co of the row-major weight matrix
      for (genvar ci = 0; ci < NCI; ci++) begin : g_col
        assign wcol[ci*DW +: DW] = y_i[(ci*NCO+co)*DW +: DW];
      end
      chblk_dot #(.N(NCI), .DW(DW), .SW(SW)) u_dot (
        .a_i  (x_i[p*NCI*DW +: NCI*DW]),
        .b_i  (wcol),
        .sum_o(sum_d[(p*NCO+co)*SW +: SW])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q_o <= '0;
    else         sum_q_o <= sum_d;
  end
endmodule

// File: rtl/chblk_acc_bank.sv
module chblk_acc_bank #(
  parameter int unsigned NOUT = 16,
  parameter int unsigned SW   = 19,
  parameter int unsigned AW   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic               acc_i,
  input  logic               clr_i,
  input  logic [NOUT*SW-1:0] sum_i,
  output logic [NOUT*AW-1:0] acc_o
);
  for (genvar l = 0; l < NOUT; l++) begin : g_lane
    logic signed [AW-1:0] ext;
    assign ext = AW'($signed(sum_i[l*SW +: SW]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              acc_o[l*AW +: AW] <= '0;
      else if (clr_i)           acc_o[l*AW +: AW] <= vld_i ? ext : '0;
      else if (vld_i && acc_i)  acc_o[l*AW +: AW] <= acc_o[l*AW +: AW] + ext;
      else if (vld_i)           acc_o[l*AW +: AW] <= ext;
    end
  end
endmodule

// File: rtl/chblk_mac_tile.sv
module chblk_mac_tile
  import chblk_mac_pkg::*;
#(
  parameter int unsigned P_NPIX = NPIX,
  parameter int unsigned P_NCI  = NCI,
  parameter int unsigned P_NCO  = NCO,
  parameter int unsigned P_DW   = DW,
  parameter int unsigned P_AW   = AW,
  localparam int unsigned L_SW   = 2 * P_DW + $clog2(P_NCI),
  localparam int unsigned L_NOUT = P_NPIX * P_NCO
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  input  logic                         acc_i,
  input  logic                         clr_i,
  input  logic [P_NPIX*P_NCI*P_DW-1:0] x_i,
  input  logic [P_NCI*P_NCO*P_DW-1:0]  y_i,
  output logic                         out_valid_o,
  output logic [L_NOUT*P_AW-1:0]       m_o
);
  logic                   vld_q, acc_q, clr_q;
  logic [L_NOUT*L_SW-1:0] sum_q;

  chblk_prod_stage #(
    .NPIX(P_NPIX), .NCI(P_NCI), .NCO(P_NCO), .DW(P_DW), .SW(L_SW)
  ) u_prod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .y_i    (y_i),
    .sum_q_o(sum_q)
  );

  // control rides alongside the product stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q       <= 1'b0;
      acc_q       <= 1'b0;
      clr_q       <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      vld_q       <= in_valid_i;
      acc_q       <= acc_i;
      clr_q       <= clr_i;
      out_valid_o <= vld_q;
    end
  end

  chblk_acc_bank #(.NOUT(L_NOUT), .SW(L_SW), .AW(P_AW)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_q),
    .acc_i (acc_q),
    .clr_i (clr_q),
    .sum_i (sum_q),
    .acc_o (m_o)
  );
endmodule

// File: rtl/chblk_mac_tile_chk.sv
module chblk_mac_tile_chk #(
  parameter int unsigned XW = 256,
  parameter int unsigned MW = 384
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          acc_i,
  input logic          clr_i,
  input logic [XW-1:0] x_i,
  input logic          out_valid_o,
  input logic [MW-1:0] m_o
);
  // R10: reset state
  always_comb begin
    if (!rst_ni) begin
      a_r10_reset_state: assert (!out_valid_o && m_o == '0);
    end
  end

  a_r6_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i, 2));

  a_r7_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i, 2) && !$past(in_valid_i, 2)) |-> (m_o == '0));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i, 2) && !$past(in_valid_i, 2)) |-> $stable(m_o));

  a_r4_zero_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_valid_i, 2) && !$past(acc_i, 2) && ($past(x_i, 2) == '0)) |-> (m_o == '0));
endmodule

bind chblk_mac_tile chblk_mac_tile_chk #(
  .XW(P_NPIX*P_NCI*P_DW), .MW(L_NOUT*P_AW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .acc_i      (acc_i),
  .clr_i      (clr_i),
  .x_i        (x_i),
  .out_valid_o(out_valid_o),
  .m_o        (m_o)
);

// File: tb/sim_chblk_mac_tile.sv
module sim_chblk_mac_tile;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0, acc_i = 1'b0, clr_i = 1'b0;
  logic [255:0] x_i = '0, y_i = '0;
  logic         out_valid_o;
  logic [383:0] m_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [383:0] model_acc = '0;
  logic         pv [2];
  logic [383:0] pm [2];
  string        pt [2];

  chblk_mac_tile u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [383:0] prod(input logic [255:0] x, input logic [255:0] y);
    logic [383:0] r = '0;
    for (int p = 0; p < 4; p++)
      for (int co = 0; co < 4; co++) begin
        int s = 0;
        for (int ci = 0; ci < 8; ci++)
          s += $signed(x[(p*8+ci)*8 +: 8]) * $signed(y[(ci*4+co)*8 +: 8]);
        r[(p*4+co)*24 +: 24] = 24'(s);
      end
    return r;
  endfunction

  task automatic check(input string tag, input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // at negedge: compare issue k-2, then drive issue k
  task automatic issue(input string tag, input logic v, input logic a, input logic c,
                       input logic [255:0] x, input logic [255:0] y);
    @(negedge clk_i);
    check({pt[1], " valid"}, 384'(out_valid_o), 384'(pv[1]));
    check({pt[1], " data"}, m_o, pm[1]);
    in_valid_i = v; acc_i = a; clr_i = c; x_i = x; y_i = y;
    if (c)              model_acc = v ? prod(x, y) : '0;
    else if (v && a) begin
      logic [383:0] pr = prod(x, y);
      for (int l = 0; l < 16; l++)
        model_acc[l*24 +: 24] = model_acc[l*24 +: 24] + pr[l*24 +: 24];
    end else if (v)     model_acc = prod(x, y);
    pv[1] = pv[0]; pm[1] = pm[0]; pt[1] = pt[0];
    pv[0] = v;     pm[0] = model_acc; pt[0] = tag;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    logic [255:0] xs, ys;
    void'($urandom(32'h5eed_1234));
    pv[0] = 0; pv[1] = 0; pm[0] = '0; pm[1] = '0; pt[0] = "R10"; pt[1] = "R10";
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R10 reset valid", 384'(out_valid_o), 384'(0));
    check("R10 reset data", m_o, '0);
    rst_ni = 1'b1;

    // R1: one-hot pixel lanes, weights all one
    for (int p = 0; p < 4; p++)
      for (int ci = 0; ci < 8; ci++) begin
        xs = '0; xs[(p*8+ci)*8 +: 8] = 8'(ci + 1);
        ys = {32{8'h01}};
        issue("R1", 1, 0, 0, xs, ys);
      end
    // R2: one-hot weight lanes, pixels distinct
    for (int l = 0; l < 32; l++) begin
      for (int i = 0; i < 32; i++) xs[i*8 +: 8] = 8'(i - 16);
      ys = '0; ys[l*8 +: 8] = 8'hfd;
      issue("R2", 1, 0, 0, xs, ys);
    end
    // R3: extreme signed operands
    issue("R3", 1, 0, 0, {32{8'h80}}, {32{8'h80}});
    issue("R3", 1, 0, 0, {32{8'h7f}}, {32{8'h80}});
    issue("R3", 1, 0, 0, {32{8'h80}}, {32{8'h7f}});
    // R4: overwrite after accumulation
    issue("R4", 1, 1, 0, rnd256(), rnd256());
    issue("R4", 1, 0, 0, rnd256(), rnd256());
    issue("R4", 1, 0, 0, '0, rnd256());
    // R5: long accumulate run to force wrap
    issue("R5", 1, 0, 0, {32{8'h80}}, {32{8'h80}});
    for (int i = 0; i < 200; i++) issue("R5", 1, 1, 0, {32{8'h80}}, {32{8'h80}});
    // R9: idle hold
    for (int i = 0; i < 5; i++) issue("R9", 0, i[0], 0, rnd256(), rnd256());
    // R7: standalone clear
    issue("R7", 0, 1, 1, rnd256(), rnd256());
    issue("R7", 0, 0, 0, rnd256(), rnd256());
    // R8: clear with accumulate and valid
    issue("R8", 1, 1, 0, rnd256(), rnd256());
    issue("R8", 1, 1, 1, rnd256(), rnd256());
    issue("R8", 1, 0, 1, rnd256(), rnd256());
    // R6: back-to-back random stream, weights held
    ys = rnd256();
    for (int i = 0; i < 200; i++) issue("R6", 1, $urandom_range(0, 1), 0, rnd256(), ys);
    // mixed random
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 15);
      issue("R6", r > 3, $urandom_range(0, 1), r == 0 || r == 15, rnd256(), rnd256());
    end
    for (int i = 0; i < 3; i++) issue("R9", 0, 0, 0, '0, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule